// File: doc/BRIEF.md
# Fractional-N Main Frequency Divider

This block divides a digitized oscillator clock by a programmable ratio and produces one single-clock pulse per divide cycle, for use as the feedback input of a phase comparator. The integer ratio is 16 bits wide. A small fractional accumulator adds a programmed increment at the end of every cycle. When that accumulator passes its modulus, the following cycle is one clock longer. The average division ratio therefore becomes the integer part plus the increment divided by the modulus. The modulus is eight or five, chosen by a select bit.

Configuration reaches the block as a shadow value: the integer ratio, the fractional increment and the modulus select, together with a load strobe. While the divider runs, a loaded value is held as pending and comes into force only at the next cycle boundary. This keeps the phase comparator from seeing a step in the middle of a cycle. A single enable input gates the whole block. Dropping the enable clears the count and the accumulator. Raising it again starts a fresh cycle with a known phase.

Top module: `fdiv_main`

## Requirements
- R1: A high `rst` at a rising edge clears the divider and sets the working ratio to 2 with increment 0 and modulus 8. `div_pulse` stays low during reset. If `en` is high when `rst` falls, the first pulse comes on the 3rd rising edge after release, and the pulses that follow are 2 clocks apart.
- R2: Each divide cycle ends with `div_pulse` high for exactly one clock. The distance between two consecutive pulses equals the ratio of the cycle that those pulses delimit.
- R3: At each pulse, the accumulator adds the increment modulo Q. If the sum before wrapping is at least Q, the next cycle lasts NMAIN+1 clocks; otherwise it lasts NMAIN clocks.
- R4: With `shadow_mod` = 0, Q is 8; with `shadow_mod` = 1, Q is 5. Any Q consecutive cycles after the first pulse add up to exactly NMAIN*Q + NF clocks.
- R5: An increment of Q or more is taken as Q-1.
- R6: An integer ratio of 0 or 1 is taken as 2.
- R7: A load while `en` is high does not change the cycle in progress. The new values apply from the next pulse on, and the accumulator keeps its contents across the change.
- R8: While `en` is low, the counter and the accumulator are cleared and a load takes effect at once. After `en` rises, the first pulse comes on the (NMAIN+1)-th rising edge with `en` high, and that cycle carries no extra count.
- R9: `div_pulse` stays low while `en` is low.
- R10: The integer ratio covers the full 16-bit range, up to 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Digitized oscillator clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low holds the divider cleared |
| load | input | 1 | Strobe that captures the shadow configuration |
| shadow_nint | input | 16 | Integer division ratio NMAIN |
| shadow_frac | input | 3 | Fractional increment NF |
| shadow_mod | input | 1 | Modulus select: 0 gives Q=8, 1 gives Q=5 |
| div_pulse | output | 1 | One-clock pulse at the end of each divide cycle |

## Verification
Several properties are checked on every cycle. A pulse never lasts longer than one clock. The counter always reloads to a nonzero value at a boundary. The accumulator stays below the modulus of the working configuration. The working configuration does not change between boundaries. With the enable low, there are no pulses and the accumulator is cleared. Other behaviours show up only through the bench's sweeps: the exact sequence of stretched cycles, the Q-cycle sum, the phase of the first pulse, the deferred-load timing and the clamping of out-of-range values. The bench compares measured pulse intervals against an arithmetic model for every increment under both moduli.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    localparam int NINT_W   = 16;
    localparam int FRAC_W   = 3;
    localparam int ACC_W    = FRAC_W + 1;
    localparam int NINT_MIN = 2;

    typedef enum logic {
        MOD_EIGHT = 1'b0,
        MOD_FIVE  = 1'b1
    } mod_sel_e;

    typedef struct packed {
        logic [NINT_W-1:0] nint;
        logic [FRAC_W-1:0] nf;
        mod_sel_e          qsel;
    } ratio_cfg_t;

    localparam ratio_cfg_t RST_CFG = '{nint: NINT_W'(NINT_MIN), nf: '0, qsel: MOD_EIGHT};

    function automatic logic [ACC_W-1:0] q_of(input mod_sel_e s);
        return (s == MOD_FIVE) ? ACC_W'(5) : ACC_W'(8);
    endfunction

    function automatic ratio_cfg_t sanitize(input ratio_cfg_t c);
        ratio_cfg_t       r;
        logic [ACC_W-1:0] qv;
        r  = c;
        qv = q_of(c.qsel);
        if (c.nint < NINT_W'(NINT_MIN))
            r.nint = NINT_W'(NINT_MIN);
        if ({1'b0, c.nf} >= qv)
            r.nf = FRAC_W'(qv - ACC_W'(1));
        return r;
    endfunction

endpackage

// File: rtl/fdiv_ratio_regs.sv
module fdiv_ratio_regs
    import fdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       load_i,
    input  ratio_cfg_t shadow_i,
    input  logic       commit_i,
    output ratio_cfg_t eff_o,
    output ratio_cfg_t work_o
);

    ratio_cfg_t shadow_s;
    ratio_cfg_t work_q;
    ratio_cfg_t pend_cfg_q;
    logic       pend_q;

    always_comb begin
        shadow_s = sanitize(shadow_i);
        if (load_i)
            eff_o = shadow_s;
        else if (pend_q)
            eff_o = pend_cfg_q;
        else
            eff_o = work_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q     <= RST_CFG;
            pend_cfg_q <= RST_CFG;
            pend_q     <= 1'b0;
        end else if (!en_i) begin
            work_q <= eff_o;
            pend_q <= 1'b0;
        end else if (commit_i) begin
            work_q <= eff_o;
            pend_q <= 1'b0;
        end else if (load_i) begin
            pend_cfg_q <= shadow_s;
            pend_q     <= 1'b1;
        end
    end

    assign work_o = work_q;

    p_hold_mid_r7: assert property (@(posedge clk) disable iff (rst)
        (en_i && !commit_i) |=> $stable(work_q))
        else $error("working ratio changed between boundaries");

    p_pend_clear_r7: assert property (@(posedge clk) disable iff (rst)
        commit_i |=> !pend_q)
        else $error("pending value not consumed at boundary");

endmodule

// File: rtl/fdiv_accum.sv
module fdiv_accum
    import fdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              step_i,
    input  logic [FRAC_W-1:0] nf_i,
    input  mod_sel_e          qsel_i,
    output logic              carry_o,
    output logic [ACC_W-1:0]  acc_o
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum_w;
    logic [ACC_W-1:0] q_w;
    logic [ACC_W-1:0] next_w;
    logic             over_w;

    always_comb begin
        q_w     = q_of(qsel_i);
        sum_w   = acc_q + ACC_W'(nf_i);
        over_w  = (sum_w >= q_w);
        next_w  = over_w ? (sum_w - q_w) : sum_w;
        carry_o = step_i && over_w;
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i)
            acc_q <= '0;
        else if (step_i)
            acc_q <= next_w;
    end

    assign acc_o = acc_q;

    p_acc_zero_off_r8: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (acc_q == '0))
        else $error("accumulator not cleared while disabled");

endmodule

// File: rtl/fdiv_counter.sv
module fdiv_counter
    import fdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [NINT_W-1:0] nint_i,
    input  logic              carry_i,
    output logic              commit_o,
    output logic              wrap_o,
    output logic              pulse_o
);

    logic [NINT_W-1:0] cnt_q;
    logic [NINT_W-1:0] reload_w;
    logic              started_q;
    logic              pulse_q;

    always_comb begin
        wrap_o   = en_i && started_q && (cnt_q == '0);
        commit_o = en_i && (!started_q || (cnt_q == '0));
        reload_w = nint_i - NINT_W'(1) + NINT_W'(carry_i);
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt_q     <= '0;
            started_q <= 1'b0;
            pulse_q   <= 1'b0;
        end else begin
            started_q <= 1'b1;
            pulse_q   <= wrap_o;
            if (commit_o)
                cnt_q <= reload_w;
            else
                cnt_q <= cnt_q - NINT_W'(1);
        end
    end

    assign pulse_o = pulse_q;

    p_pulse_gap_r2: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q)
        else $error("output pulse wider than one clock");

    p_reload_nz_r2: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (cnt_q != '0))
        else $error("boundary reload gave a ratio below two");

    p_off_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !pulse_q)
        else $error("pulse while disabled");

endmodule

// File: rtl/fdiv_main.sv
module fdiv_main
    import fdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              load,
    input  logic [NINT_W-1:0] shadow_nint,
    input  logic [FRAC_W-1:0] shadow_frac,
    input  logic              shadow_mod,
    output logic              div_pulse
);

    ratio_cfg_t       shadow_w;
    ratio_cfg_t       eff_w;
    ratio_cfg_t       work_w;
    logic             commit_w;
    logic             wrap_w;
    logic             carry_w;
    logic [ACC_W-1:0] acc_w;

    always_comb begin
        shadow_w.nint = shadow_nint;
        shadow_w.nf   = shadow_frac;
        shadow_w.qsel = mod_sel_e'(shadow_mod);
    end

    fdiv_ratio_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .en_i     (en),
        .load_i   (load),
        .shadow_i (shadow_w),
        .commit_i (commit_w),
        .eff_o    (eff_w),
        .work_o   (work_w)
    );

    fdiv_accum u_acc (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en),
        .step_i  (wrap_w),
        .nf_i    (eff_w.nf),
        .qsel_i  (eff_w.qsel),
        .carry_o (carry_w),
        .acc_o   (acc_w)
    );

    fdiv_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .en_i     (en),
        .nint_i   (eff_w.nint),
        .carry_i  (carry_w),
        .commit_o (commit_w),
        .wrap_o   (wrap_w),
        .pulse_o  (div_pulse)
    );

    p_acc_bound_r4: assert property (@(posedge clk) disable iff (rst)
        acc_w < q_of(work_w.qsel))
        else $error("accumulator outside working modulus");

endmodule

// File: tb/sim_fdiv_main.sv
module sim_fdiv_main;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        load = 1'b0;
    logic [15:0] s_n = '0;
    logic [2:0]  s_f = '0;
    logic        s_m = 1'b0;
    logic        pulse;

    int edge_cnt = 0;
    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;
    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    fdiv_main u0 (
        .clk(clk), .rst(rst), .en(en), .load(load),
        .shadow_nint(s_n), .shadow_frac(s_f), .shadow_mod(s_m),
        .div_pulse(pulse)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_load(input int n, input int f, input int m);
        @(negedge clk);
        s_n = n[15:0]; s_f = f[2:0]; s_m = m[0]; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic wait_pulse(output int t);
        do @(negedge clk); while (pulse !== 1'b1);
        t = edge_cnt;
    endtask

    task automatic start_run(output int t0);
        @(negedge clk);
        en = 1'b1;
        t0 = edge_cnt;
    endtask

    task automatic stop_run();
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
    endtask

    // Sweep one configuration against the arithmetic model
    task automatic run_check(input int n, input int f, input int m, input int nf_e, input int n_e);
        int q, t0, t, prev, acc, ov, sum;
        q = (m != 0) ? 5 : 8;
        cfg_load(n, f, m);
        start_run(t0);
        wait_pulse(t);
        chk("R8 first pulse phase", t - t0, n_e + 1);
        prev = t; acc = 0; sum = 0;
        for (int k = 1; k <= 2 * q; k++) begin
            wait_pulse(t);
            acc = acc + nf_e;
            ov = (acc >= q) ? 1 : 0;
            if (ov != 0) acc = acc - q;
            chk("R3 interval", t - prev, n_e + ov);
            if (k <= q) sum = sum + (t - prev);
            if (k == q) chk("R4 sum over Q cycles", sum, n_e * q + nf_e);
            prev = t;
        end
        @(negedge clk);
        chk("R2 pulse width", pulse, 0);
        stop_run();
    endtask

    initial begin
        int t0, t, prev, seen;
        int ns[3];
        int exp7[4];
        int exp8[3];

        // R1: reset
        seen = 0;
        repeat (5) begin @(negedge clk); if (pulse) seen++; end
        chk("R1 no pulse in reset", seen, 0);
        rst = 1'b0;

        // R9: quiet while disabled, loads included
        seen = 0;
        cfg_load(3, 1, 0);
        repeat (30) begin @(negedge clk); if (pulse) seen++; end
        chk("R9 no pulse while disabled", seen, 0);

        // Sweep over both moduli and every valid increment
        ns[0] = 2; ns[1] = 3; ns[2] = 7;
        for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < ((m != 0) ? 5 : 8); f++) begin
                for (int i = 0; i < 3; i++)
                    run_check(ns[i], f, m, f, ns[i]);
            end
        end

        // R5: increment clamp
        run_check(6, 7, 1, 4, 6);
        run_check(6, 5, 1, 4, 6);
        // R6: ratio clamp
        run_check(0, 0, 0, 0, 2);
        run_check(1, 3, 0, 3, 2);

        // R7: load while running applies at the boundary, accumulator kept
        cfg_load(10, 3, 0);
        start_run(t0);
        wait_pulse(t);
        chk("R8 first pulse phase", t - t0, 11);
        prev = t;
        repeat (3) @(negedge clk);
        cfg_load(20, 5, 0);
        exp7[0] = 10; exp7[1] = 21; exp7[2] = 20; exp7[3] = 21;
        for (int k = 0; k < 4; k++) begin
            wait_pulse(t);
            chk("R7 deferred load interval", t - prev, exp7[k]);
            prev = t;
        end
        stop_run();

        // R8: disable mid-run clears state
        cfg_load(4, 3, 0);
        start_run(t0);
        repeat (3) wait_pulse(t);
        stop_run();
        start_run(t0);
        wait_pulse(t);
        chk("R8 restart phase", t - t0, 5);
        prev = t;
        exp8[0] = 4; exp8[1] = 4; exp8[2] = 5;
        for (int k = 0; k < 3; k++) begin
            wait_pulse(t);
            chk("R8 restart interval", t - prev, exp8[k]);
            prev = t;
        end

        // R1: reset while enabled restores ratio 2
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        t0 = edge_cnt;
        wait_pulse(t);
        chk("R1 first pulse after reset", t - t0, 3);
        prev = t;
        for (int k = 0; k < 3; k++) begin
            wait_pulse(t);
            chk("R1 interval after reset", t - prev, 2);
            prev = t;
        end
        stop_run();

        // R10: full 16-bit ratio
        cfg_load(65535, 0, 0);
        start_run(t0);
        wait_pulse(t);
        chk("R10 max ratio first pulse", t - t0, 65536);
        stop_run();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(20 * 190000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule